// File: doc/BRIEF.md
# Two-Port Sample Demultiplexer with Reset Realignment

This block takes one sample on every rising edge of the sample clock and hands the samples out in pairs on two ports, auxiliary and primary, at half the input rate. It also drives a half-rate data-ready output. Both ports and data-ready change together on the rising edge of data-ready. Within each pair the older sample always sits on the auxiliary port.

A synchronous reset input passes through a two-stage synchronizer and is then compared against the phase of the divide-by-two toggle. If the reset rises while data-ready is high, the toggle holds for one extra input cycle. This drops one input cycle and lines data-ready up with the reset. The first pair after that drop is out of sequence, and the even/odd split across the ports swaps.

A reset output is provided for downstream demultiplexers. When no drop is needed, it follows the synchronized reset and changes only on data-ready rising edges, so its falling edge marks the start of the aligned phase. When a drop is needed, the reset output stays low for that whole reset assertion. For a dependable system reset, hold the reset input for several data-ready periods.

Top module: `pair_demux`

## Requirements
- R1: While `rst_n` is low, `aux_out` and `pri_out` read 0, and `dready` and `rst_out` are low.
- R2: With no realignment, `dready` inverts on every clock edge.
- R3: `aux_out`, `pri_out` and `rst_out` change only on an edge where `dready` rises, and hold for the full data-ready period.
- R4: On a normal `dready` rising edge, `pri_out` takes the sample present at that edge and `aux_out` takes the sample from one edge earlier, so the older sample is on the auxiliary port.
- R5: `rst_in` is synchronized by two registers. The rising edge of the synchronized reset is acted on one edge later. If `dready` is high at that edge, `dready` stays high for one extra cycle, and one input sample is dropped.
- R6: The first pair after a drop has `pri_out - aux_out = 2` (modulo 2^W). Every other pair has a difference of 1, and after the drop the parity of the samples on each port is swapped.
- R7: For a reset in matching phase, `rst_out` rises at the first `dready` rising edge that sees the synchronized reset high. It falls at the first `dready` rising edge that sees it low.
- R8: If a reset event caused a drop, `rst_out` stays low until the synchronized reset has gone low again.
- R9: A one-cycle `rst_in` pulse realigns like a longer one. In matching phase it gives a `rst_out` pulse of one data-ready period. In the opposite phase it gives a drop and no `rst_out` pulse.
- R10: A matching-phase reset held for N input cycles, with N even, gives a `rst_out` pulse of N input cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sample_in | input | W | One sample per clock |
| rst_in | input | 1 | Realignment reset request, synchronous |
| aux_out | output | W | Older sample of each pair |
| pri_out | output | W | Newer sample of each pair |
| dready | output | 1 | Half-rate data-ready clock |
| rst_out | output | 1 | Reset passed on to downstream demultiplexers |

## Verification
A wrong divider phase appears on `dready` within one clock, and it shifts the next port load by one cycle. A stale hold register or a missed skip shows up at the next `dready` rise as a pair difference other than 1 or 2. A suppression flag stuck in the wrong state either hides or produces a `rst_out` pulse at the first data-ready rise after the synchronized reset rises, about three clocks after `rst_in`.

// File: rtl/pair_demux.sv
module pair_demux #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample_in,
  input  logic         rst_in,
  output logic [W-1:0] aux_out,
  output logic [W-1:0] pri_out,
  output logic         dready,
  output logic         rst_out
);

  logic         ph, skip, sup;
  logic         rs1, rs2, rs3;
  logic [W-1:0] hold;

  wire rise  = rs2 & ~rs3;
  wire swal  = rise & ph;
  wire load  = ~ph;

  assign dready = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rs1, rs2, rs3} <= '0;
    end else begin
      rs1 <= rst_in;
      rs2 <= rs1;
      rs3 <= rs2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= 1'b0;
      skip <= 1'b0;
      sup  <= 1'b0;
    end else begin
      ph   <= swal ? 1'b1 : ~ph;
      skip <= swal;
      if (swal)      sup <= 1'b1;
      else if (!rs2) sup <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      aux_out <= '0;
      pri_out <= '0;
      rst_out <= 1'b0;
    end else begin
      if (ph && !skip) hold <= sample_in;
      if (load) begin
        aux_out <= hold;
        pri_out <= sample_in;
        rst_out <= rs2 & ~sup;
      end
    end
  end

  // R2
  dready_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swal |=> dready != $past(dready));

  // R3
  ports_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pri_out) && $stable(aux_out) && $stable(rst_out));

  // R4
  pri_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pri_out == $past(sample_in));

  // R5
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swal |=> dready && skip);

  // R8
  no_rstout_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swal && !rst_out |=> !rst_out);

endmodule

// File: tb/pair_demux_tb.sv
module pair_demux_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic         rst_in = 1'b0;
  logic [W-1:0] aux_out, pri_out;
  logic         dready, rst_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pair_demux #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .rst_in(rst_in),
    .aux_out(aux_out), .pri_out(pri_out), .dready(dready), .rst_out(rst_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: history of synchronized reset and samples
  int m_ph, m_skip, m_sup, m_hold, m_aux, m_pri, m_rst;
  int rq[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_skip = 0; m_sup = 0; m_hold = 0; m_aux = 0; m_pri = 0; m_rst = 0;
      rq = '{0, 0, 0};
    end else begin
      int sync_now, sync_old, drop;
      sync_now = rq[1];
      sync_old = rq[2];
      drop = (sync_now == 1 && sync_old == 0 && m_ph == 1);
      if (m_ph == 0) begin
        m_aux = m_hold; m_pri = int'(sample_in);
        m_rst = (sync_now == 1 && m_sup == 0);
      end
      if (m_ph == 1 && m_skip == 0) m_hold = int'(sample_in);
      m_ph = drop ? 1 : 1 - m_ph;
      m_skip = drop;
      if (drop) m_sup = 1; else if (sync_now == 0) m_sup = 0;
      rq.push_front(int'(rst_in));
      void'(rq.pop_back());
    end
  end

  // window observation counters
  bit win = 0;
  int c_rst, c_gap2, c_hold, prev_dr;
  always @(negedge clk) begin
    if (rst_n) begin
      check(aux_out == m_aux[W-1:0], "R4 aux", aux_out, m_aux);
      check(pri_out == m_pri[W-1:0], "R4 pri", pri_out, m_pri);
      check(dready == m_ph[0], "R2 dready", dready, m_ph);
      check(rst_out == m_rst[0], "R3/R7 rst_out", rst_out, m_rst);
    end
    if (win) begin
      logic [W-1:0] d;
      d = pri_out - aux_out;
      if (rst_out) c_rst++;
      if (dready && prev_dr == 1) c_hold++;
      if (dready && prev_dr == 0 && d == 2) c_gap2++;
    end
    prev_dr = dready;
    sample_in <= sample_in + 1'b1;
  end

  task automatic scenario(input int phase, input int len, input int exp_rst,
                          input int exp_drop, input string req);
    do @(negedge clk); while (dready != phase[0]);
    c_rst = 0; c_gap2 = 0; c_hold = 0; win = 1;
    rst_in = 1'b1;
    repeat (len) @(negedge clk);
    rst_in = 1'b0;
    repeat (30) @(negedge clk);
    win = 0;
    check(c_rst == exp_rst, {req, " rst_out cycles"}, c_rst, exp_rst);
    check(c_hold == exp_drop, {req, " dropped cycles"}, c_hold, exp_drop);
    check(c_gap2 == exp_drop, {req, " out-of-sequence pairs"}, c_gap2, exp_drop);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(aux_out == 0 && pri_out == 0, "R1 ports", pri_out, 0);
    check(dready == 0 && rst_out == 0, "R1 dready/rst_out", {dready, rst_out}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    scenario(0, 2, 2, 0, "R7 matched");
    scenario(1, 2, 0, 1, "R5 R6 R8 realigned");
    scenario(0, 1, 2, 0, "R9 one-cycle matched");
    scenario(1, 1, 0, 1, "R9 one-cycle realigned");
    scenario(0, 8, 8, 0, "R10 long matched");
    scenario(1, 8, 0, 1, "R8 long realigned");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule